// File: doc/BRIEF.md
# Pattern-Buffer Multichannel PWM Generator

The block produces up to eight pulse-width-modulated outputs by replaying a stored table of output bytes. A reload down-counter generates an underflow tick once every `RELOAD+1` clock cycles. On each tick the next byte of an internal pattern buffer is copied to an 8-bit output register. Each bit of that register drives one PWM pin. After `N` entries the read index wraps to entry 0 and playback repeats. `N` is therefore the PWM resolution, and the PWM period is `N*(RELOAD+1)` clocks.

Duty cycle is not set by a compare threshold. It is set by how many of the `N` entries have a given bit set, so each output can carry an arbitrary waveform shape within the period. A host fills the buffer through a simple write port. It sets the reload value and the entry count through a configuration write. An enable input freezes playback.

Top module: `pattern_pwm_gen`

## Requirements
- R1: While `en` is high, a tick occurs every `RELOAD+1` clock cycles. `pwm_out` changes only on the clock edge of a tick.
- R2: After reset, the first enabled clock edge is a tick that loads buffer entry 0 into `pwm_out`. Each following tick loads the next entry, in increasing order.
- R3: The tick that follows the output of entry `N-1` loads entry 0 again, and playback repeats without limit.
- R4: Bit k of the output register drives `pwm_out[k]`. Over any window of one full period, output k is high for (number of entries among 0..N-1 with bit k set) × (RELOAD+1) cycles.
- R5: `N` is programmable from 1 to 256 and is encoded as `cfg_len_m1 = N-1`. With N=1 the output holds entry 0, and with N=256 every buffer entry is played.
- R6: A buffer write to an entry changes nothing on `pwm_out` at the time of the write. The new value appears when that entry is next read by a tick.
- R7: While `en` is low, the tick counter, the read index and `pwm_out` all hold. No tick occurs.
- R8: Asserting `rst_n` low clears `pwm_out` to 0 at once. Reset also clears the read index and the tick counter.
- R9: A clock edge with `cfg_we` high captures `cfg_reload` as RELOAD and `cfg_len_m1` as N-1. Both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Playback enable |
| buf_we | input | 1 | Pattern buffer write strobe |
| buf_addr | input | 8 | Pattern buffer entry to write |
| buf_wdata | input | 8 | Byte written to the entry |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_reload | input | 16 | Tick interval minus one |
| cfg_len_m1 | input | 8 | Entry count minus one |
| pwm_out | output | 8 | PWM outputs, one per bit |

## Verification
The bench builds the block with its default parameters: 8 channels, a 256-entry buffer and a 16-bit reload. It uses small reload values (0 to 2), so a whole period and its wrap fit in a few hundred cycles. This allows a cycle-by-cycle comparison against an arithmetic model for N = 1, 7, 10 and the full 256 entries. One run sets eight distinct duty counts, one per bit, and compares the measured high-time of every output with the count of set bits. Other runs cover a rewrite of the entry currently on the pins, a pause through `en`, and a reset in mid-run.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CH_W_DEF  = 8;
  localparam int unsigned DEPTH_DEF = 256;
  localparam int unsigned RLD_W_DEF = 16;
endpackage

// File: rtl/pwm_tick_timer.sv
module pwm_tick_timer #(
  parameter int unsigned RLD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [RLD_W-1:0] reload,
  output logic             tick,
  output logic [RLD_W-1:0] cnt_q
);
  logic [RLD_W-1:0] cnt_d;

  always_comb begin
    tick  = en && (cnt_q == '0);
    cnt_d = cnt_q;
    if (en) begin
      if (cnt_q == '0) cnt_d = reload;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_pattern_buf.sv
module pwm_pattern_buf #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [CH_W-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [CH_W-1:0] rdata
);
  logic [CH_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pwm_play_index.sv
module pwm_play_index #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] len_m1,
  output logic [AW-1:0] idx_q
);
  logic [AW-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (tick) begin
      if (idx_q >= len_m1) idx_d = '0;
      else                 idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (tick) idx_q <= idx_d;
  end
endmodule

// File: rtl/pattern_pwm_gen.sv
module pattern_pwm_gen #(
  parameter int unsigned CH_W  = pwm_pkg::CH_W_DEF,
  parameter int unsigned DEPTH = pwm_pkg::DEPTH_DEF,
  parameter int unsigned RLD_W = pwm_pkg::RLD_W_DEF,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_addr,
  input  logic [CH_W-1:0]  buf_wdata,
  input  logic             cfg_we,
  input  logic [RLD_W-1:0] cfg_reload,
  input  logic [AW-1:0]    cfg_len_m1,
  output logic [CH_W-1:0]  pwm_out
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [RLD_W-1:0] reload_q;
  logic [AW-1:0]    len_m1_q;
  logic             tick;
  logic [RLD_W-1:0] cnt_q;
  logic [AW-1:0]    idx_q;
  logic [CH_W-1:0]  rd_byte;
  logic [CH_W-1:0]  out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      reload_q <= '0;
      len_m1_q <= '0;
    end else if (cfg_we) begin
      reload_q <= cfg_reload;
      len_m1_q <= cfg_len_m1;
    end
  end

  pwm_tick_timer #(.RLD_W(RLD_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .reload(reload_q),
    .tick(tick), .cnt_q(cnt_q)
  );

  pwm_play_index #(.AW(AW)) u_index (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .len_m1(len_m1_q),
    .idx_q(idx_q)
  );

  pwm_pattern_buf #(.CH_W(CH_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_addr), .wdata(buf_wdata),
    .raddr(idx_q), .rdata(rd_byte)
  );

  always_comb begin
    out_d = pwm_out;
    if (tick) out_d = rd_byte;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pwm_out <= '0;
    else if (tick)   pwm_out <= out_d;
  end
endmodule

// File: rtl/pattern_pwm_chk.sv
module pattern_pwm_chk #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned AW    = 8,
  parameter int unsigned RLD_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic [RLD_W-1:0] cnt_q,
  input logic [RLD_W-1:0] reload_q,
  input logic [AW-1:0]    idx_q,
  input logic [AW-1:0]    len_m1_q,
  input logic [CH_W-1:0]  pwm_out
);
  // R1: output register moves only on a tick
  p_out_only_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm_out));
  // R1: counter restarts from the reload value after a tick
  p_reload_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(reload_q)));
  // R2: index advances by one inside the table
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (idx_q < len_m1_q)) |=> (idx_q == $past(idx_q) + 1'b1));
  // R3: index wraps after the last entry
  p_idx_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (idx_q >= len_m1_q)) |=> (idx_q == '0));
  // R7: paused block does not tick
  p_no_tick_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);
  // R7: paused block holds its state
  p_hold_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pwm_out) && $stable(idx_q) && $stable(cnt_q)));
endmodule

bind pattern_pwm_gen pattern_pwm_chk #(.CH_W(CH_W), .AW(AW), .RLD_W(RLD_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .en(en), .tick(tick), .cnt_q(cnt_q),
  .reload_q(reload_q), .idx_q(idx_q), .len_m1_q(len_m1_q), .pwm_out(pwm_out)
);

// File: tb/pattern_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module pattern_pwm_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        buf_we;
  logic [7:0]  buf_addr;
  logic [7:0]  buf_wdata;
  logic        cfg_we;
  logic [15:0] cfg_reload;
  logic [7:0]  cfg_len_m1;
  logic [7:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_mem [256];

  always #5 clk = ~clk;

  pattern_pwm_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .cfg_we(cfg_we), .cfg_reload(cfg_reload),
    .cfg_len_m1(cfg_len_m1), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; buf_we = 1'b0; cfg_we = 1'b0;
    #1;
    chk("R8", {24'd0, pwm_out}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_entry(input int a, input logic [7:0] v);
    @(negedge clk);
    buf_we = 1'b1; buf_addr = 8'(a); buf_wdata = v;
    exp_mem[a] = v;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic configure(input int r, input int n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_reload = 16'(r); cfg_len_m1 = 8'(n - 1);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // cycle-exact playback comparison; wr_t >= 0 rewrites the entry on the pins
  task automatic run_seq(input int r, input int n, input int seed, input int wr_t, input string tag);
    logic [7:0] exp_out;
    int wrote;
    do_reset();
    for (int j = 0; j < n; j++) load_entry(j, 8'((j * 37 + 5 + seed) & 8'hFF));
    configure(r, n);
    @(negedge clk);
    en = 1'b1;
    exp_out = 8'h00;
    wrote = 0;
    for (int t = 0; t < 2 * n * (r + 1) + 3; t++) begin
      string req;
      @(posedge clk);
      #1;
      buf_we = 1'b0;
      if (t % (r + 1) == 0) exp_out = exp_mem[(t / (r + 1)) % n];
      if (tag != "")                 req = tag;
      else if (wrote != 0)           req = "R6";
      else if (t % (r + 1) != 0)     req = "R1";
      else if (t / (r + 1) >= n)     req = "R3";
      else                           req = "R2";
      chk(req, {24'd0, pwm_out}, {24'd0, exp_out});
      if (t == wr_t) begin
        int k;
        k = (t / (r + 1)) % n;
        exp_mem[k] = ~exp_mem[k];
        buf_we = 1'b1; buf_addr = 8'(k); buf_wdata = exp_mem[k];
        wrote = 1;
      end
    end
    buf_we = 1'b0;
    en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int duty [8] = '{3, 7, 0, 10, 1, 5, 9, 2};
    int hi [8];
    logic [7:0] held;
    rst_n = 1'b0; en = 1'b0; buf_we = 1'b0; cfg_we = 1'b0;
    buf_addr = '0; buf_wdata = '0; cfg_reload = '0; cfg_len_m1 = '0;
    repeat (3) @(negedge clk);
    chk("R8", {24'd0, pwm_out}, 32'd0);

    run_seq(2, 10, 0, -1, "");
    run_seq(2, 10, 3, 4, "");        // R6: entry 1 rewritten while on the pins
    run_seq(0, 1, 9, -1, "R5");      // R5: single-entry table
    run_seq(0, 256, 17, -1, "R5");   // R5: full 256-entry table
    run_seq(1, 7, 41, -1, "R9");     // R9: captured reload and length

    // R4: duty measurement, bit k set in entries j < duty[k]
    do_reset();
    for (int j = 0; j < 10; j++) begin
      logic [7:0] v;
      for (int k = 0; k < 8; k++) v[k] = (j < duty[k]);
      load_entry(j, v);
    end
    configure(2, 10);
    @(negedge clk);
    en = 1'b1;
    repeat (40) @(negedge clk);
    for (int k = 0; k < 8; k++) hi[k] = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      for (int k = 0; k < 8; k++) if (pwm_out[k]) hi[k]++;
    end
    for (int k = 0; k < 8; k++) chk("R4", 32'(hi[k]), 32'(duty[k] * 3));

    // R7: pause holds the pins
    @(negedge clk);
    en = 1'b0;
    held = pwm_out;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk("R7", {24'd0, pwm_out}, {24'd0, held});
    end

    // R8: reset in mid-run clears the pins at once
    en = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8", {24'd0, pwm_out}, 32'd0);
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: index restarted, first enabled edge shows entry 0 (reload/length back to 0)
    en = 1'b1;
    @(posedge clk);
    #1;
    chk("R8", {24'd0, pwm_out}, {24'd0, exp_mem[0]});
    en = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule